// File: doc/BRIEF.md
# Quasi-bidirectional port with boost pullup

This block keeps the output latch for a group of quasi-bidirectional pins and turns it into per-bit digital enables for the pad drivers: a low-side sink enable, a weak pullup enable and a short strong (boost) pullup enable. There is no direction register. A latch bit of 0 pulls its pin low through an open-drain sink. A latch bit of 1 releases the pin, which can then serve as an input or as an output that is held high.

The serial interface core presents a write strobe together with a data byte, and a single-cycle event for each falling edge of the serial clock. A write that sets a bit to 1 starts that bit's boost pullup, which gives a fast rising edge into a heavily loaded pin. The next serial-clock falling edge ends the boost.

The pin levels pass through a two-flop synchronizer. The synchronized value is offered as readback data and is also the feed for transition detection elsewhere. Readback always reports what the pins actually show, never what the latch holds.

Top module: `qbd_port`

## Requirements
- R1: After reset every latch bit is 1. So sink_en is all 0, weak_pu_en is all 1, boost_en is all 0 and rd_data is all 1.
- R2: A cycle with wr_stb high loads wr_data into the latch. From the next cycle on, sink_en equals the bitwise inverse of that data.
- R3: weak_pu_en bit i is 1 exactly when latch bit i is 1, and 0 while that bit is 0.
- R4: rd_data is pin_in delayed by exactly two clock edges. It is independent of the latch contents.
- R5: A write sets boost_en to the written data in the cycle that follows: bits written 1 turn on and bits written 0 turn off.
- R6: In a cycle with scl_fall high and wr_stb low, every boost_en bit clears at the next edge. In a cycle with neither wr_stb nor scl_fall, boost_en holds its value.
- R7: Writing 1 to a bit whose latch is already 1 turns its boost on again.
- R8: For any bit, boost_en and sink_en are never 1 together.
- R9: When wr_stb and scl_fall are high in the same cycle, the write decides boost_en, which then equals the written data.
- R10: While wr_stb is low, the latch, sink_en and weak_pu_en keep their values whatever wr_data and scl_fall do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_stb | input | 1 | One-cycle write strobe from the serial core |
| wr_data | input | W | Byte to load into the latch |
| scl_fall | input | 1 | One-cycle event for a serial-clock falling edge |
| pin_in | input | W | Raw pin levels from the pads |
| sink_en | output | W | Per-bit open-drain low drive enable |
| weak_pu_en | output | W | Per-bit weak pullup enable |
| boost_en | output | W | Per-bit transient strong pullup enable |
| rd_data | output | W | Synchronized pin levels for readback |

## Verification
The case hardest to reach from the ports is a write that collides with a serial-clock falling edge in the same cycle. The other hard case is a write of 1 to a bit that is already high, where the boost must fire again even though the latch does not change. The stimulus lines up wr_stb and scl_fall on the same edge on purpose, and writes all-ones twice with a clearing edge in between. The bench also sweeps all 256 write values with a clearing edge after each one, and all 256 pin patterns while the latch holds all zeros. This shows that readback follows the pins rather than the latch, with the two-edge latency.

// File: rtl/qbd_port.sv
module qbd_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_data,
  input  logic         scl_fall,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] sink_en,
  output logic [W-1:0] weak_pu_en,
  output logic [W-1:0] boost_en,
  output logic [W-1:0] rd_data
);

  localparam logic [W-1:0] ALL_HI = {W{1'b1}};

  logic [W-1:0] latch_q;
  logic [W-1:0] boost_q;
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= ALL_HI;
    else if (wr_stb) latch_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boost_q <= '0;
    else if (wr_stb) boost_q <= wr_data;
    else if (scl_fall) boost_q <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= ALL_HI;
      sync_q <= ALL_HI;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
    end
  end

  assign sink_en    = ~latch_q;
  assign weak_pu_en = latch_q;
  assign boost_en   = boost_q;
  assign rd_data    = sync_q;

endmodule

// File: rtl/qbd_port_chk.sv
module qbd_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_stb,
  input logic [W-1:0] wr_data,
  input logic         scl_fall,
  input logic [W-1:0] sink_en,
  input logic [W-1:0] weak_pu_en,
  input logic [W-1:0] boost_en
);

  AST_BOOST_SINK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (boost_en & sink_en) == '0); // R8

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> sink_en == ~$past(wr_data)); // R2

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> ($stable(sink_en) && $stable(weak_pu_en))); // R10

  AST_BOOST_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> boost_en == $past(wr_data)); // R5

  AST_BOOST_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && scl_fall) |=> boost_en == '0); // R6

  AST_BOOST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && !scl_fall) |=> $stable(boost_en)); // R6

  AST_BOOST_ONLY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (boost_en & ~weak_pu_en) == '0); // R3

endmodule

bind qbd_port qbd_port_chk #(.W(W)) u_qbd_port_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_stb     (wr_stb),
  .wr_data    (wr_data),
  .scl_fall   (scl_fall),
  .sink_en    (sink_en),
  .weak_pu_en (weak_pu_en),
  .boost_en   (boost_en)
);

// File: tb/test_qbd_port.sv
module test_qbd_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic       scl_fall = 1'b0;
  logic [7:0] pin_in = 8'hFF;
  logic [7:0] sink_en, weak_pu_en, boost_en, rd_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  qbd_port #(.W(8)) i_qbd_port (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .scl_fall(scl_fall), .pin_in(pin_in), .sink_en(sink_en),
    .weak_pu_en(weak_pu_en), .boost_en(boost_en), .rd_data(rd_data)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic write(input logic [7:0] d, input logic fall);
    wr_stb = 1'b1; wr_data = d; scl_fall = fall;
    step();
    wr_stb = 1'b0; scl_fall = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1 sink", sink_en, 8'h00);
    chk("R1 weak", weak_pu_en, 8'hFF);
    chk("R1 boost", boost_en, 8'h00);
    chk("R1 rd", rd_data, 8'hFF);
    rst_n = 1'b1;
    step();
    chk("R1 sink after release", sink_en, 8'h00);

    for (int v = 0; v < 256; v++) begin
      write(8'(v), 1'b0);
      chk("R2 sink", sink_en, ~8'(v));
      chk("R3 weak", weak_pu_en, 8'(v));
      chk("R5 boost", boost_en, 8'(v));
      chk("R8 excl", boost_en & sink_en, 8'h00);
      wr_data = ~8'(v); scl_fall = 1'b1;
      step();
      scl_fall = 1'b0;
      chk("R6 boost cut", boost_en, 8'h00);
      chk("R10 sink kept", sink_en, ~8'(v));
      chk("R10 weak kept", weak_pu_en, 8'(v));
      wr_data = 8'h3C;
      step();
      chk("R6 boost held", boost_en, 8'h00);
      chk("R10 no strobe", sink_en, ~8'(v));
    end

    write(8'hFF, 1'b0);
    scl_fall = 1'b1; step(); scl_fall = 1'b0;
    chk("R6 cut before rewrite", boost_en, 8'h00);
    write(8'hFF, 1'b0);
    chk("R7 rewrite high", boost_en, 8'hFF);
    chk("R7 latch high", weak_pu_en, 8'hFF);

    write(8'h5A, 1'b1);
    chk("R9 collide boost", boost_en, 8'h5A);
    chk("R9 collide sink", sink_en, 8'hA5);
    write(8'h00, 1'b1);
    chk("R9 collide zero", boost_en, 8'h00);

    for (int v = 0; v < 256; v++) begin
      logic [7:0] prev;
      prev = rd_data;
      pin_in = 8'(v);
      step();
      chk("R4 one edge", rd_data, prev);
      step();
      chk("R4 two edges", rd_data, 8'(v));
      chk("R4 latch kept", sink_en, 8'hFF);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule